// File: doc/BRIEF.md
# Register-Mapped Byte-Stream Frame Port

This block lets a processor exchange whole network frames with a byte-wide stream link, one byte per register access. On receive, the block collects an arriving frame into a local buffer and publishes its length in a receive count register. Software then reads the receive data port repeatedly; each read hands back the next byte and lowers the count by one until it reaches zero.

On transmit, software arms a length in the transmit count register and then writes that many bytes to the transmit data port. Once the last armed byte has been written, the block streams the frame out on its transmit link. When the final byte has been taken, it clears the transmit count to zero. Three interrupt sources feed a single interrupt line: transmit done, receive done and a software test bit. The window also holds a fixed 64-bit identifier, a busy flag and a read-only interrupt information word.

Top module: `bfp_top`

## Requirements
- R1: After reset the receive and transmit counts and the busy flag read 0, `irq` is low, `tx_valid` is low and `rx_ready` is high.
- R2: Offset 0x00 returns identifier bits 31:0 and offset 0x04 returns bits 63:32. The identifier is the eight-character text `ID_TEXT`, with its first character in bits 7:0 and each later character one byte higher.
- R3: When the byte marked `rx_last` is accepted, the receive count (offset 0x0C) takes the frame's byte count. `rx_ready` stays low for as long as that count is nonzero.
- R4: A read of the receive data port (offset 0x1C) with a nonzero count returns the frame's next byte in arrival order and decrements the count. With a zero count, the read returns 0 and the count stays 0.
- R5: After a nonzero length N is written to offset 0x10, the first N writes to offset 0x20 are sent on the transmit link in write order, with `tx_last` on the N-th byte. Further writes to 0x20 are ignored. `tx_valid` and `tx_data` hold while `tx_ready` is low.
- R6: The transmit count reads 0 from the cycle after the last byte's handshake. The busy flag (offset 0x08, bit 0) reads 1 while a frame is being received or a transmit is armed or sending, and 0 otherwise.
- R7: Only bits 7:0 of the data ports carry data: receive data reads have bits 31:8 zero, and bits 31:8 of transmit data writes are ignored.
- R8: In the interrupt control register (offset 0x14), bit 0 is set when a transmit completes and bit 1 when a receive frame is loaded. Writing 1 to either bit clears it. Writing a value with bit 31 set sets the test bit, and writing 0 clears it. `irq` is high while any of the three bits is set.
- R9: Offset 0x18 reads the `INFO_VALUE` parameter. Offsets 0x24 to 0x3C read 0.
- R10: A receive frame longer than `DEPTH` bytes keeps its first `DEPTH` bytes and loads a count of `DEPTH`. The remaining bytes are accepted and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset in the register window, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on the read strobe's edge |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the final byte of a receive frame |
| rx_ready | output | 1 | Block can accept a receive byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Marks the final byte of a transmit frame |
| tx_ready | input | 1 | Link accepts the transmit byte |
| irq | output | 1 | Interrupt, high while any source bit is set |

## Verification
A register read is due in `bus_rdata` after the clock edge that samples the strobe, so the bench raises the strobe for one cycle and reads the data at the falling edge that follows. A read of the receive data port lowers the count on that same edge. `rx_ready` falls on the edge that accepts the last byte, and the receive-done bit and `irq` rise on that edge too. `tx_valid` rises on the edge after the last armed data write. The transmit count clears and the transmit-done bit rises on the edge of the final handshake. A scoreboard monitor compares each transmit byte at the falling edge before the handshake edge. Polled reads of the count and interrupt register then see every state change, because each one lands a whole cycle before the sample.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  localparam logic [5:0] OFS_ID_LO = 6'h00;
  localparam logic [5:0] OFS_ID_HI = 6'h04;
  localparam logic [5:0] OFS_BUSY  = 6'h08;
  localparam logic [5:0] OFS_RXCNT = 6'h0C;
  localparam logic [5:0] OFS_TXCNT = 6'h10;
  localparam logic [5:0] OFS_ICTL  = 6'h14;
  localparam logic [5:0] OFS_INFO  = 6'h18;
  localparam logic [5:0] OFS_RXDAT = 6'h1C;
  localparam logic [5:0] OFS_TXDAT = 6'h20;

  localparam int FLAG_TX   = 0;
  localparam int FLAG_RX   = 1;
  localparam int FLAG_TEST = 31;

  typedef enum logic [1:0] {TX_IDLE, TX_LOAD, TX_SEND} tx_state_e;

  // A string literal places its first character in the top byte; the
  // window wants it in the bottom byte, so reverse the byte order.
  function automatic logic [63:0] chars_lsb_first(input logic [63:0] s);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = s[8*(7-i) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/bfp_rx.sv
module bfp_rx #(
  parameter int DEPTH = 64,
  parameter int CW    = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  input  logic          pop_req,
  output logic [7:0]    pop_data,
  output logic [CW-1:0] count,
  output logic          filling,
  output logic          frame_done
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] fill_len;
  logic [PW-1:0] rd_ptr;
  logic          accept;

  // Length after one more byte, saturating at the buffer depth.
  function automatic logic [PW-1:0] grow(input logic [PW-1:0] n);
    return (n < PW'(DEPTH)) ? n + PW'(1) : PW'(DEPTH);
  endfunction

  assign in_ready   = (count == '0);
  assign accept     = in_valid && in_ready;
  assign frame_done = accept && in_last;
  assign filling    = (fill_len != '0);
  assign pop_data   = (count != '0) ? mem[rd_ptr[AW-1:0]] : 8'h00;

  always_ff @(posedge clk) begin
    if (accept && fill_len < PW'(DEPTH)) mem[fill_len[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      fill_len <= '0;
      rd_ptr   <= '0;
    end else if (accept) begin
      if (in_last) begin
        count    <= CW'(grow(fill_len));
        fill_len <= '0;
        rd_ptr   <= '0;
      end else begin
        fill_len <= grow(fill_len);
      end
    end else if (pop_req && count != '0) begin
      count  <= count - CW'(1);
      rd_ptr <= rd_ptr + PW'(1);
    end
  end
endmodule

// File: rtl/bfp_tx.sv
module bfp_tx
  import bfp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_we,
  input  logic [31:0]   arm_val,
  input  logic          data_we,
  input  logic [7:0]    data_byte,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  input  logic          out_ready,
  output logic [CW-1:0] count,
  output logic          active,
  output logic          frame_sent
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(DEPTH + 1);

  tx_state_e     state;
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] len_q;
  logic [PW-1:0] wr_idx;
  logic [PW-1:0] rd_idx;
  logic          load_we;

  // An armed length larger than the buffer is cut to the buffer depth.
  function automatic logic [PW-1:0] clamp_len(input logic [31:0] v);
    return (v > 32'(DEPTH)) ? PW'(DEPTH) : PW'(v);
  endfunction

  assign load_we    = (state == TX_LOAD) && data_we;
  assign out_valid  = (state == TX_SEND);
  assign out_data   = mem[rd_idx[AW-1:0]];
  assign out_last   = out_valid && (rd_idx + PW'(1) == len_q);
  assign frame_sent = out_valid && out_ready && out_last;
  assign active     = (state != TX_IDLE);
  assign count      = CW'(len_q);

  always_ff @(posedge clk) begin
    if (load_we) mem[wr_idx[AW-1:0]] <= data_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= TX_IDLE;
      len_q  <= '0;
      wr_idx <= '0;
      rd_idx <= '0;
    end else begin
      unique case (state)
        TX_IDLE: if (arm_we && arm_val != 32'd0) begin
          len_q  <= clamp_len(arm_val);
          wr_idx <= '0;
          state  <= TX_LOAD;
        end
        TX_LOAD: if (data_we) begin
          wr_idx <= wr_idx + PW'(1);
          if (wr_idx + PW'(1) == len_q) begin
            rd_idx <= '0;
            state  <= TX_SEND;
          end
        end
        TX_SEND: if (out_ready) begin
          if (out_last) begin
            len_q <= '0;
            state <= TX_IDLE;
          end else begin
            rd_idx <= rd_idx + PW'(1);
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bfp_irq.sv
module bfp_irq
  import bfp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        tx_evt,
  input  logic        rx_evt,
  output logic [31:0] flags,
  output logic        irq
);
  logic tx_f, rx_f, test_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_f   <= 1'b0;
      rx_f   <= 1'b0;
      test_f <= 1'b0;
    end else begin
      // A completion event in the same cycle as a clear wins.
      if (tx_evt)                        tx_f <= 1'b1;
      else if (wr_en && wdata[FLAG_TX])  tx_f <= 1'b0;
      if (rx_evt)                        rx_f <= 1'b1;
      else if (wr_en && wdata[FLAG_RX])  rx_f <= 1'b0;
      if (wr_en && wdata == 32'd0)       test_f <= 1'b0;
      else if (wr_en && wdata[FLAG_TEST]) test_f <= 1'b1;
    end
  end

  always_comb begin
    flags            = '0;
    flags[FLAG_TX]   = tx_f;
    flags[FLAG_RX]   = rx_f;
    flags[FLAG_TEST] = test_f;
  end

  assign irq = tx_f | rx_f | test_f;
endmodule

// File: rtl/bfp_top.sv
module bfp_top
  import bfp_pkg::*;
#(
  parameter int          DEPTH      = 64,
  parameter int          MAX_FRAME  = 65536,
  parameter logic [63:0] ID_TEXT    = "BYTEPRT1",
  parameter logic [31:0] INFO_VALUE = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready,
  output logic        irq
);
  localparam int          CW      = $clog2(MAX_FRAME + 1);
  localparam logic [63:0] ID_WORD = chars_lsb_first(ID_TEXT);

  logic          rx_pop, tx_arm_we, tx_dat_we, ictl_we;
  logic [7:0]    rx_byte;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic          rx_filling, rx_frame_done;
  logic          tx_active, tx_frame_sent;
  logic [31:0]   ictl_val;
  logic          busy;
  logic [31:0]   rd_value;

  assign rx_pop    = bus_rd && bus_addr == OFS_RXDAT;
  assign tx_arm_we = bus_wr && bus_addr == OFS_TXCNT;
  assign tx_dat_we = bus_wr && bus_addr == OFS_TXDAT;
  assign ictl_we   = bus_wr && bus_addr == OFS_ICTL;
  assign busy      = rx_filling || tx_active;

  bfp_rx #(.DEPTH(DEPTH), .CW(CW)) rx_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_valid), .in_data(rx_data), .in_last(rx_last), .in_ready(rx_ready),
    .pop_req(rx_pop), .pop_data(rx_byte), .count(rx_cnt),
    .filling(rx_filling), .frame_done(rx_frame_done)
  );

  bfp_tx #(.DEPTH(DEPTH), .CW(CW)) tx_i (
    .clk(clk), .rst_n(rst_n),
    .arm_we(tx_arm_we), .arm_val(bus_wdata),
    .data_we(tx_dat_we), .data_byte(bus_wdata[7:0]),
    .out_valid(tx_valid), .out_data(tx_data), .out_last(tx_last), .out_ready(tx_ready),
    .count(tx_cnt), .active(tx_active), .frame_sent(tx_frame_sent)
  );

  bfp_irq irq_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ictl_we), .wdata(bus_wdata),
    .tx_evt(tx_frame_sent), .rx_evt(rx_frame_done),
    .flags(ictl_val), .irq(irq)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_ID_LO: rd_value = ID_WORD[31:0];
      OFS_ID_HI: rd_value = ID_WORD[63:32];
      OFS_BUSY:  rd_value = {31'd0, busy};
      OFS_RXCNT: rd_value = 32'(rx_cnt);
      OFS_TXCNT: rd_value = 32'(tx_cnt);
      OFS_ICTL:  rd_value = ictl_val;
      OFS_INFO:  rd_value = INFO_VALUE;
      OFS_RXDAT: rd_value = {24'd0, rx_byte};
      default:   rd_value = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= 32'd0;
    else if (bus_rd) bus_rdata <= rd_value;
  end
endmodule

// File: rtl/bfp_chk.sv
module bfp_chk #(
  parameter int CW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic [5:0]    bus_addr,
  input logic [31:0]   bus_rdata,
  input logic          rx_valid,
  input logic          rx_last,
  input logic          rx_ready,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          tx_ready,
  input logic          irq,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic          rx_pop,
  input logic          rx_frame_done
);
  AST_RX_READY_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt != '0 |-> !rx_ready); // R3
  AST_RX_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_cnt != '0) |=> rx_cnt == $past(rx_cnt) - CW'(1)); // R4
  AST_RX_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_cnt == '0 && !(rx_valid && rx_ready && rx_last)) |=> rx_cnt == '0); // R4
  AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 6'h1C) |=> bus_rdata[31:8] == 24'd0); // R7
  AST_TX_VALID_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_cnt != '0); // R5
  AST_TX_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data)); // R5
  AST_TX_CLEAR_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> tx_cnt == '0 && irq); // R6
  AST_RX_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_done |=> irq); // R8
  AST_HIGH_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr > 6'h20) |=> bus_rdata == 32'd0); // R9
endmodule

bind bfp_top bfp_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .rx_valid(rx_valid), .rx_last(rx_last), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
  .irq(irq), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .rx_pop(rx_pop), .rx_frame_done(rx_frame_done)
);

// File: tb/bfp_top_tb_top.sv
module bfp_top_tb_top;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid, tx_last;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic        irq;

  int checks = 0, failures = 0, tx_seen = 0, cyc = 0;
  logic [8:0] expq[$];

  always #2.5 clk = ~clk;

  bfp_top #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rx_frame(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!rx_ready) @(negedge clk);
      rx_valid = 1'b1; rx_data = seed + 8'(i); rx_last = (i == n - 1);
    end
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  // Link-side backpressure pattern, changed just after each rising edge.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    tx_ready <= (cyc % 3) != 1;
  end

  // Scoreboard monitor: compares each transmit handshake with the queue head.
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      tx_seen++;
      if (expq.size() == 0) chk(1'b0, "R5 unexpected tx byte", tx_data, 0);
      else begin
        logic [8:0] e;
        e = expq.pop_front();
        chk({tx_last, tx_data} == e, "R5 tx byte/last", {tx_last, tx_data}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] id_exp;
    string idt;
    idt = "BYTEPRT1";
    for (int i = 0; i < 8; i++) id_exp[8*i +: 8] = idt[i];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_ready == 1'b1, "R1 rx_ready after reset", rx_ready, 1);
    chk(tx_valid == 1'b0, "R1 tx_valid after reset", tx_valid, 0);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    rd(6'h08, d); chk(d == 0, "R1 busy after reset", d, 0);
    rd(6'h0C, d); chk(d == 0, "R1 rx count after reset", d, 0);
    rd(6'h10, d); chk(d == 0, "R1 tx count after reset", d, 0);

    rd(6'h00, d); chk(d == id_exp[31:0], "R2 id low word", d, id_exp[31:0]);
    rd(6'h04, d); chk(d == id_exp[63:32], "R2 id high word", d, id_exp[63:32]);

    rd(6'h18, d); chk(d == 0, "R9 info word", d, 0);
    rd(6'h24, d); chk(d == 0, "R9 offset 0x24", d, 0);
    rd(6'h3C, d); chk(d == 0, "R9 offset 0x3C", d, 0);

    // Receive a five-byte frame.
    rx_frame(5, 8'hA0);
    chk(rx_ready == 1'b0, "R3 rx_ready low while count nonzero", rx_ready, 0);
    rd(6'h0C, d); chk(d == 5, "R3 rx count loaded", d, 5);
    chk(irq == 1'b1, "R8 irq on rx done", irq, 1);
    rd(6'h14, d); chk(d == 32'h2, "R8 rx done bit", d, 2);
    rd(6'h08, d); chk(d == 0, "R6 busy idle after rx", d, 0);
    for (int i = 0; i < 5; i++) begin
      rd(6'h1C, d);
      chk(d == 32'(8'hA0 + 8'(i)), "R4 rx byte order", d, 8'hA0 + 8'(i));
      chk(d[31:8] == 0, "R7 rx upper bits zero", d[31:8], 0);
      if (i == 1) begin
        rd(6'h0C, d); chk(d == 3, "R4 count after two reads", d, 3);
      end
    end
    rd(6'h1C, d); chk(d == 0, "R4 empty read returns zero", d, 0);
    rd(6'h0C, d); chk(d == 0, "R4 empty read keeps count", d, 0);
    chk(rx_ready == 1'b1, "R3 rx_ready back high", rx_ready, 1);

    wr(6'h14, 32'h2);
    @(negedge clk); chk(irq == 1'b0, "R8 rx done cleared", irq, 0);
    wr(6'h14, 32'h8000_0000);
    @(negedge clk); chk(irq == 1'b1, "R8 test bit raises irq", irq, 1);
    rd(6'h14, d); chk(d == 32'h8000_0000, "R8 test bit reads back", d, 32'h8000_0000);
    wr(6'h14, 32'h0);
    @(negedge clk); chk(irq == 1'b0, "R8 zero write clears test", irq, 0);

    // Transmit four bytes, then two surplus writes.
    wr(6'h10, 32'd4);
    rd(6'h08, d); chk(d == 1, "R6 busy while tx armed", d, 1);
    for (int i = 0; i < 6; i++) begin
      if (i < 4) expq.push_back({(i == 3), 8'h30 + 8'(i)});
      wr(6'h20, {24'hABCD12, 8'h30 + 8'(i)});
    end
    d = 1;
    for (int k = 0; k < 50 && d != 0; k++) rd(6'h10, d);
    chk(d == 0, "R6 tx count cleared", d, 0);
    rd(6'h08, d); chk(d == 0, "R6 busy cleared after tx", d, 0);
    chk(irq == 1'b1, "R8 irq on tx done", irq, 1);
    rd(6'h14, d); chk(d == 32'h1, "R8 tx done bit", d, 1);
    repeat (4) @(negedge clk);
    chk(tx_seen == 4 && expq.size() == 0, "R5 exactly armed bytes sent", tx_seen, 4);
    wr(6'h14, 32'h1);

    // Overlong receive frame is cut to the buffer depth.
    rx_frame(DEPTH + 6, 8'h05);
    rd(6'h0C, d); chk(d == DEPTH, "R10 truncated count", d, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      rd(6'h1C, d);
      chk(d == 32'(8'h05 + 8'(i)), "R10 truncated frame byte", d, 8'h05 + 8'(i));
    end
    rd(6'h0C, d); chk(d == 0, "R10 count drained", d, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule